// File: doc/BRIEF.md
# Full-Bridge Gate Driver with Blanked Cycle-by-Cycle Current Limit

This block drives the two legs of a full bridge from a PWM carrier. While the carrier is high, leg A conducts through its upper switch and leg B conducts through its lower switch. While the carrier is low, the roles swap. Every carrier transition starts a new half cycle. The upper and lower switch enables of each leg are complementary, and a programmable dead time separates them.

A digital over-current comparator flag feeds a two-flop synchronizer. The flag is high when current is acceptable and low when current is too high. A falling edge of the synchronized flag ends the active upper switch for the rest of the current half cycle, and that leg then freewheels on its lower switch after the dead time. Such an edge is honoured only after a blanking interval, counted in clocks from each carrier transition, so that switching noise at the start of a half cycle cannot cut the drive short. Every honoured edge produces a one-clock event strobe and sets a flag that marks the half cycle as ended early.

Top module: `bridge_limit_drv`

## Requirements
- R1: When `enable` is high and the outputs have settled, `pwm_carrier`=1 gives a_hi=1, a_lo=0, b_hi=0, b_lo=1. `pwm_carrier`=0 gives the mirror image.
- R2: The upper and lower enables of one leg are never high together. When a switch of a leg turns off, both switches of that leg stay off for exactly `dead_cycles`+1 clocks before the complement turns on.
- R3: When `cmp_ok` falls outside blanking and is first sampled low at clock edge k, the active upper switch is off after edge k+2. It is still on after edge k+1.
- R4: A terminated leg stays off on its upper switch and turns on its lower switch `dead_cycles`+1 clocks after the trip. Normal drive resumes at the next carrier transition.
- R5: Let h be the clock edge that first samples a new carrier level and N the value of `blank_cycles`. A `cmp_ok` fall first sampled at edge h+j is ignored for -2 <= j <= N-2 and is acted on for j >= N-1.
- R6: Every honoured trip raises `limit_evt` for exactly one clock, and `term_flag` is set in that same clock. Only the first trip of a half cycle is honoured.
- R7: With `enable` low, all four drive outputs are low after the next clock edge and no trip is honoured. After `enable` returns high, the carrier's side drives again after one edge.
- R8: During reset all drive outputs, `limit_evt` and `term_flag` are low.
- R9: `term_flag` clears only after a clock edge that samples a change of `pwm_carrier`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global drive enable |
| pwm_carrier | input | 1 | Half-cycle carrier, 1 = leg A upper active |
| blank_cycles | input | BLANK_W | Blanking length in clocks |
| dead_cycles | input | DEAD_W | Dead time in clocks (gap is value+1) |
| cmp_ok | input | 1 | Comparator flag, low = over current |
| a_hi | output | 1 | Leg A upper switch enable |
| a_lo | output | 1 | Leg A lower switch enable |
| b_hi | output | 1 | Leg B upper switch enable |
| b_lo | output | 1 | Leg B lower switch enable |
| limit_evt | output | 1 | One-clock strobe per honoured trip |
| term_flag | output | 1 | Current half cycle ended early |

## Verification
The properties are checked on every clock:
- no leg has both switches on, and no lower switch turns on in the clock after its upper switch turns off;
- disable forces all outputs low;
- the strobe lasts one clock, coincides with the flag and with both upper switches off, and never comes from a blanked or transition cycle;
- the flag clears only after a carrier change.

The exact three-edge trip latency, the exact boundary of the blanking window, the exact dead-time gap and the resumption of drive in the next half cycle depend on counted cycles. Only the bench's directed scenarios show those.

// File: rtl/gd_pkg.sv
package gd_pkg;

  // Falling transition between two successive samples.
  function automatic logic falling(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // A comparator fall ends the drive only when enabled, outside blanking,
  // not on the carrier transition cycle, and not already terminated.
  function automatic logic trip_ok(input logic en, input logic fall,
                                   input logic blanked, input logic new_half,
                                   input logic already);
    return en & fall & ~blanked & ~new_half & ~already;
  endfunction

endpackage

// File: rtl/gd_cmp_edge.sv
module gd_cmp_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_raw,
  output logic cmp_fall
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '1;
      last_q <= 1'b1;
    end else begin
      chain  <= {chain[SYNC_STAGES-2:0], cmp_raw};
      last_q <= chain[SYNC_STAGES-1];
    end
  end

  assign cmp_fall = gd_pkg::falling(last_q, chain[SYNC_STAGES-1]);
endmodule

// File: rtl/gd_blank_timer.sv
module gd_blank_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] length,
  output logic         active
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= length;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/gd_leg.sv
module gd_leg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         want_hi,
  input  logic [W-1:0] dead,
  output logic         hi,
  output logic         lo
);
  logic [W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      hi  <= 1'b0;
      lo  <= 1'b0;
      gap <= '0;
    end else if (hi && !want_hi) begin
      hi  <= 1'b0;
      gap <= dead;
    end else if (lo && want_hi) begin
      lo  <= 1'b0;
      gap <= dead;
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
    end else if (!hi && !lo) begin
      hi <= want_hi;
      lo <= ~want_hi;
    end
  end
endmodule

// File: rtl/bridge_limit_drv.sv
module bridge_limit_drv #(
  parameter int BLANK_W     = 8,
  parameter int DEAD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               pwm_carrier,
  input  logic [BLANK_W-1:0] blank_cycles,
  input  logic [DEAD_W-1:0]  dead_cycles,
  input  logic               cmp_ok,
  output logic               a_hi,
  output logic               a_lo,
  output logic               b_hi,
  output logic               b_lo,
  output logic               limit_evt,
  output logic               term_flag
);
  localparam int NLEG = 2;

  logic            carrier_q;
  logic            hc_start;
  logic            cmp_fall;
  logic            blank_active;
  logic            trip;
  logic            term_q;
  logic            evt_q;
  logic            kill;
  logic [NLEG-1:0] want_hi;
  logic [NLEG-1:0] leg_hi;
  logic [NLEG-1:0] leg_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) carrier_q <= 1'b0;
    else        carrier_q <= pwm_carrier;
  end

  assign hc_start = pwm_carrier ^ carrier_q;

  gd_cmp_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_ok), .cmp_fall(cmp_fall)
  );

  gd_blank_timer #(.W(BLANK_W)) i_blank (
    .clk(clk), .rst_n(rst_n), .start(hc_start),
    .length(blank_cycles), .active(blank_active)
  );

  assign trip = gd_pkg::trip_ok(enable, cmp_fall, blank_active, hc_start, term_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= trip;
      if (hc_start)  term_q <= 1'b0;
      else if (trip) term_q <= 1'b1;
    end
  end

  // Upper switch of the active leg is killed on the trip edge itself.
  assign kill       = (term_q & ~hc_start) | trip;
  assign want_hi[0] = pwm_carrier & ~kill;
  assign want_hi[1] = ~pwm_carrier & ~kill;

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    gd_leg #(.W(DEAD_W)) i_leg (
      .clk(clk), .rst_n(rst_n), .en(enable), .want_hi(want_hi[i]),
      .dead(dead_cycles), .hi(leg_hi[i]), .lo(leg_lo[i])
    );
  end

  assign a_hi      = leg_hi[0];
  assign a_lo      = leg_lo[0];
  assign b_hi      = leg_hi[1];
  assign b_lo      = leg_lo[1];
  assign limit_evt = evt_q;
  assign term_flag = term_q;
endmodule

// File: rtl/gd_limit_checker.sv
module gd_limit_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic pwm_carrier,
  input logic a_hi,
  input logic a_lo,
  input logic b_hi,
  input logic b_lo,
  input logic limit_evt,
  input logic term_flag,
  input logic blank_active,
  input logic hc_start
);
  // R2
  leg_a_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(a_hi && a_lo));
  // R2
  leg_b_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(b_hi && b_lo));
  // R2
  leg_a_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(a_hi) |-> !a_lo);
  // R2
  leg_b_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(b_hi) |-> !b_lo);
  // R7
  disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(a_hi || a_lo || b_hi || b_lo));
  // R6
  evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) limit_evt |-> term_flag);
  // R6
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) limit_evt |=> !limit_evt);
  // R3
  evt_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_evt |-> (!a_hi && !b_hi));
  // R5
  evt_unblanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_evt |-> $past(!blank_active && !hc_start));
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(term_flag) |-> ($past(pwm_carrier) != $past(pwm_carrier, 2)));
endmodule

bind bridge_limit_drv gd_limit_checker i_gd_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_carrier(pwm_carrier),
  .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
  .limit_evt(limit_evt), .term_flag(term_flag),
  .blank_active(blank_active), .hc_start(hc_start)
);

// File: tb/test_bridge_limit_drv.sv
module test_bridge_limit_drv;
  localparam int BW = 8;
  localparam int DW = 4;
  localparam int NBLANK = 10;
  localparam int NDEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic pwm_carrier = 1'b0;
  logic [BW-1:0] blank_cycles = BW'(NBLANK);
  logic [DW-1:0] dead_cycles = DW'(NDEAD);
  logic cmp_ok = 1'b1;
  logic a_hi, a_lo, b_hi, b_lo, limit_evt, term_flag;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bridge_limit_drv #(.BLANK_W(BW), .DEAD_W(DW)) i_bridge_limit_drv (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_carrier(pwm_carrier),
    .blank_cycles(blank_cycles), .dead_cycles(dead_cycles), .cmp_ok(cmp_ok),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .limit_evt(limit_evt), .term_flag(term_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    tick(4);
    check("R8 outputs in reset", {a_hi, a_lo, b_hi, b_lo}, 0);
    check("R8 evt in reset", limit_evt, 0);
    check("R8 flag in reset", term_flag, 0);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic t_normal();
    enable = 1'b1;
    pwm_carrier = 1'b1;
    tick(NBLANK + 4);
    check("R1 carrier high", {a_hi, a_lo, b_hi, b_lo}, 4'b1001);
    pwm_carrier = 1'b0;
    tick(1);
    check("R2 a_hi off at transition", a_hi, 0);
    check("R2 b_lo off at transition", b_lo, 0);
    for (int j = 0; j < NDEAD; j++) begin
      tick(1);
      check("R2 gap both off", {a_hi, a_lo, b_hi, b_lo}, 0);
    end
    tick(1);
    check("R1 R2 carrier low after gap", {a_hi, a_lo, b_hi, b_lo}, 4'b0110);
    tick(NBLANK);
  endtask

  task automatic t_trip();
    cmp_ok = 1'b0;
    tick(2);
    check("R3 still on after k+1", b_hi, 1);
    check("R3 no early evt", limit_evt, 0);
    tick(1);
    check("R3 b_hi off after k+2", b_hi, 0);
    check("R6 evt strobe", limit_evt, 1);
    check("R6 flag set with strobe", term_flag, 1);
    tick(1);
    check("R6 strobe one clock", limit_evt, 0);
    tick(NDEAD);
    check("R4 freewheel lower on", b_lo, 1);
    cmp_ok = 1'b1;
    tick(5);
    cmp_ok = 1'b0;
    for (int j = 0; j < 6; j++) begin
      tick(1);
      check("R6 second fall ignored", limit_evt, 0);
    end
    check("R4 upper stays off", b_hi, 0);
    check("R4 flag held", term_flag, 1);
    cmp_ok = 1'b1;
    pwm_carrier = 1'b1;
    tick(1);
    check("R9 flag clears on transition", term_flag, 0);
    tick(NDEAD + 1);
    check("R4 drive resumes", {a_hi, a_lo, b_hi, b_lo}, 4'b1001);
    tick(NBLANK);
  endtask

  task automatic t_blank();
    pwm_carrier = 1'b0;
    tick(1);
    tick(NBLANK - 3);
    cmp_ok = 1'b0;
    for (int j = 0; j < 20; j++) begin
      tick(1);
      check("R5 blanked fall ignored", limit_evt, 0);
    end
    check("R5 drive kept", b_hi, 1);
    check("R5 flag stays clear", term_flag, 0);
    cmp_ok = 1'b1;
    tick(3);
    pwm_carrier = 1'b1;
    tick(1);
    tick(NBLANK - 2);
    cmp_ok = 1'b0;
    tick(3);
    check("R5 first unblanked fall acted", limit_evt, 1);
    check("R5 drive cut", a_hi, 0);
    cmp_ok = 1'b1;
    tick(3);
  endtask

  task automatic t_enable();
    pwm_carrier = 1'b0;
    tick(NDEAD + 2);
    check("R1 driving before disable", {a_hi, a_lo, b_hi, b_lo}, 4'b0110);
    enable = 1'b0;
    tick(1);
    check("R7 all low one edge after disable", {a_hi, a_lo, b_hi, b_lo}, 0);
    cmp_ok = 1'b0;
    for (int j = 0; j < 6; j++) begin
      tick(1);
      check("R7 no trip while disabled", limit_evt, 0);
    end
    check("R7 outputs held low", {a_hi, a_lo, b_hi, b_lo}, 0);
    cmp_ok = 1'b1;
    tick(3);
    enable = 1'b1;
    tick(1);
    check("R7 drive returns", {a_hi, a_lo, b_hi, b_lo}, 4'b0110);
    check("R7 flag clear", term_flag, 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_trip();
    t_blank();
    t_enable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule